// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block produces a 4-bit noise sample for a sound generator. A 15-bit shift register with feedback advances each time a programmable period divider expires. A length counter decides whether the voice is audible, and the envelope unit supplies the level. The sample equals that level while the length count is nonzero and the low bit of the shift register is clear. Otherwise the sample is zero.

Software writes three byte-wide control locations, chosen by a 2-bit select:
- Select 0 holds the level settings.
- Select 2 holds the tone settings.
- Select 3 loads the length counter and restarts the envelope.

A frame sequencer outside this block supplies three inputs:
- quarter-frame strobes, which clock the envelope;
- half-frame strobes, which clock the length counter;
- an indicator that marks a cycle in which the length counter is being clocked.

A level enable input gates the length counter. The period and length tables are parameters. A region parameter picks one of two period tables.

Top module: `noise_voice`

## Requirements
- R1: After synchronous reset the sample is 0, the shift register holds 1, the length count and envelope decay level are 0, and the period divider expires on the first clock after reset is released.
- R2: The shift register is 15 bits. On each divider expiry it shifts right and the feedback bit enters bit 14. When bit 7 of the tone location (select 2) is 0, the feedback is bit 0 XOR bit 1.
- R3: When bit 7 of the tone location is 1, the feedback is bit 0 XOR bit 6.
- R4: The sample is registered. One cycle after any state, it equals the current level when the length count is nonzero and shift register bit 0 is 0, and it is 0 otherwise.
- R5: Bits 3:0 of the tone location index the period table. The divider expires every P cycles and reloads from the index held at expiry. Default region 0 has index 0 = 4 cycles and index 3 = 32 cycles.
- R6: A write to select 3 loads the length count from the length table at bits 7:3. Index 1 = 254, index 3 = 2 and index 5 = 4. A half-frame strobe decrements a nonzero count.
- R7: Bit 5 of the level location (select 0) freezes the length count against half-frame strobes.
- R8: While the enable input is low, the length count becomes 0 on the next clock and length loads are ignored.
- R9: A length load that arrives with the length-clocked indicator high while the count is nonzero is refused. The same load is accepted when the count is zero.
- R10: With bit 4 of the level location set, the level is bits 3:0 of that location.
- R11: With bit 4 clear, a select-3 write arms a restart, and the next quarter strobe sets the decay level to 15 and the divider to bits 3:0. After that, the decay level drops once every (bits 3:0 + 1) quarter strobes and stops at 0. When bit 5 is set, it wraps from 0 back to 15 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 2 | Control location select (0 level, 2 tone, 3 length) |
| wr_data | input | 8 | Control write data |
| qtr_tick | input | 1 | Quarter-frame strobe (envelope clock) |
| half_tick | input | 1 | Half-frame strobe (length clock) |
| chan_en | input | 1 | Voice enable level |
| len_busy | input | 1 | Length counter is being clocked this cycle |
| sample_out | output | 4 | Registered noise sample |

## Verification
Two functions can coincide in one cycle:
- a length load and a half-frame length clock;
- an envelope restart write and a quarter strobe.

The bench provokes the first case by issuing a select-3 write in the same cycle as a half strobe with the busy indicator high. It does this once with a nonzero count, where the load must be refused and the decrement taken, and once with a zero count, where the load must be accepted. In each case the verdict comes from the number of half strobes that pass before the sample falls permanently silent. A predictor derived from the requirements judges every output cycle, including the envelope restarts that land on quarter strobes.

// File: rtl/noise_pkg.sv
package noise_pkg;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_SPARE = 2'd1,
    SEL_TONE  = 2'd2,
    SEL_LOAD  = 2'd3
  } nz_sel_e;

  // Period tables, entry 0 in the least significant 12 bits.
  localparam logic [191:0] PER_REGION0 = {
    12'd4068, 12'd2034, 12'd1016, 12'd762, 12'd508, 12'd380, 12'd254, 12'd202,
    12'd160,  12'd128,  12'd96,   12'd64,  12'd32,  12'd16,  12'd8,   12'd4};

  localparam logic [191:0] PER_REGION1 = {
    12'd3778, 12'd1890, 12'd944, 12'd708, 12'd472, 12'd354, 12'd236, 12'd188,
    12'd148,  12'd118,  12'd88,  12'd60,  12'd30,  12'd14,  12'd8,   12'd4};

  // Length table, entry 0 in the least significant byte.
  localparam logic [255:0] LEN_TABLE_DEF = {
    8'd30, 8'd32, 8'd28, 8'd16, 8'd26, 8'd72, 8'd24, 8'd192,
    8'd22, 8'd96, 8'd20, 8'd48, 8'd18, 8'd24, 8'd16, 8'd12,
    8'd14, 8'd26, 8'd12, 8'd14, 8'd10, 8'd60, 8'd8,  8'd160,
    8'd6,  8'd80, 8'd4,  8'd40, 8'd2,  8'd20, 8'd254, 8'd10};

endpackage

// File: rtl/nz_timer.sv
module nz_timer #(
  parameter int PER_W = 12,
  parameter int PER_N = 16,
  parameter int REGION = 0,
  parameter logic [PER_W*PER_N-1:0] TBL_A = noise_pkg::PER_REGION0,
  parameter logic [PER_W*PER_N-1:0] TBL_B = noise_pkg::PER_REGION1,
  localparam int IDX_W = $clog2(PER_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             tick
);

  localparam logic [PER_W-1:0] ONE = {{(PER_W-1){1'b0}}, 1'b1};

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] reload;

  generate
    if (REGION == 0) begin : g_region_a
      assign reload = TBL_A[idx*PER_W +: PER_W];
    end else begin : g_region_b
      assign reload = TBL_B[idx*PER_W +: PER_W];
    end
  endgenerate

  assign tick = (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ONE;
    end else if (tick) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/nz_lfsr.sv
module nz_lfsr #(
  parameter int W      = 15,
  parameter int TAP_M0 = 1,
  parameter int TAP_M1 = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         mode,
  output logic [W-1:0] q
);

  logic fb;

  assign fb = q[0] ^ (mode ? q[TAP_M1] : q[TAP_M0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {{(W-1){1'b0}}, 1'b1};
    end else if (step) begin
      q <= {fb, q[W-1:1]};
    end
  end

endmodule

// File: rtl/nz_length.sv
module nz_length #(
  parameter int LEN_W = 8,
  parameter int LEN_N = 32,
  parameter logic [LEN_W*LEN_N-1:0] LEN_TABLE = noise_pkg::LEN_TABLE_DEF,
  localparam int SEL_W = $clog2(LEN_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             halt,
  input  logic             half_tick,
  input  logic             len_busy,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic [LEN_W-1:0] cnt
);

  logic nonzero;
  logic load_ok;

  assign nonzero = (cnt != '0);
  assign load_ok = load && !(len_busy && nonzero);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (load_ok) begin
      cnt <= LEN_TABLE[sel*LEN_W +: LEN_W];
    end else if (half_tick && !halt && nonzero) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/nz_env.sv
module nz_env #(
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qtr_tick,
  input  logic             restart,
  input  logic             loop_en,
  input  logic             const_vol,
  input  logic [VOL_W-1:0] setting,
  output logic [VOL_W-1:0] level
);

  logic             start_q;
  logic [VOL_W-1:0] div_q;
  logic [VOL_W-1:0] decay_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      div_q   <= '0;
      decay_q <= '0;
    end else begin
      if (qtr_tick) begin
        if (start_q) begin
          start_q <= 1'b0;
          decay_q <= '1;
          div_q   <= setting;
        end else if (div_q == '0) begin
          div_q <= setting;
          if (decay_q != '0) begin
            decay_q <= decay_q - 1'b1;
          end else if (loop_en) begin
            decay_q <= '1;
          end
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
      if (restart) begin
        start_q <= 1'b1;
      end
    end
  end

  assign level = const_vol ? setting : decay_q;

endmodule

// File: rtl/noise_voice.sv
module noise_voice #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 15,
  parameter int TAP_M0 = 1,
  parameter int TAP_M1 = 6,
  parameter int PER_W  = 12,
  parameter int PER_N  = 16,
  parameter int REGION = 0,
  parameter logic [PER_W*PER_N-1:0] PER_TBL_A = noise_pkg::PER_REGION0,
  parameter logic [PER_W*PER_N-1:0] PER_TBL_B = noise_pkg::PER_REGION1,
  parameter int LEN_W  = 8,
  parameter int LEN_N  = 32,
  parameter logic [LEN_W*LEN_N-1:0] LEN_TABLE = noise_pkg::LEN_TABLE_DEF,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              qtr_tick,
  input  logic              half_tick,
  input  logic              chan_en,
  input  logic              len_busy,
  output logic [VOL_W-1:0]  sample_out
);

  import noise_pkg::*;

  localparam int IDX_W   = $clog2(PER_N);
  localparam int LSEL_W  = $clog2(LEN_N);
  localparam int HALT_B  = 5;
  localparam int CONST_B = 4;
  localparam int MODE_B  = DATA_W - 1;

  logic              halt_q;
  logic              constv_q;
  logic [VOL_W-1:0]  vol_q;
  logic              mode_q;
  logic [IDX_W-1:0]  idx_q;

  logic              shift_tick;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LEN_W-1:0]  len_cnt;
  logic [VOL_W-1:0]  level;
  logic              load_wr;

  assign load_wr = wr_en && (nz_sel_e'(wr_sel) == SEL_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q   <= 1'b0;
      constv_q <= 1'b0;
      vol_q    <= '0;
      mode_q   <= 1'b0;
      idx_q    <= '0;
    end else if (wr_en) begin
      if (nz_sel_e'(wr_sel) == SEL_LEVEL) begin
        halt_q   <= wr_data[HALT_B];
        constv_q <= wr_data[CONST_B];
        vol_q    <= wr_data[VOL_W-1:0];
      end
      if (nz_sel_e'(wr_sel) == SEL_TONE) begin
        mode_q <= wr_data[MODE_B];
        idx_q  <= wr_data[IDX_W-1:0];
      end
    end
  end

  nz_timer #(
    .PER_W(PER_W), .PER_N(PER_N), .REGION(REGION),
    .TBL_A(PER_TBL_A), .TBL_B(PER_TBL_B)
  ) u_timer (
    .clk(clk), .rst(rst), .idx(idx_q), .tick(shift_tick)
  );

  nz_lfsr #(.W(LFSR_W), .TAP_M0(TAP_M0), .TAP_M1(TAP_M1)) u_lfsr (
    .clk(clk), .rst(rst), .step(shift_tick), .mode(mode_q), .q(lfsr_q)
  );

  nz_length #(.LEN_W(LEN_W), .LEN_N(LEN_N), .LEN_TABLE(LEN_TABLE)) u_len (
    .clk(clk), .rst(rst), .en(chan_en), .halt(halt_q),
    .half_tick(half_tick), .len_busy(len_busy), .load(load_wr),
    .sel(wr_data[DATA_W-1 -: LSEL_W]), .cnt(len_cnt)
  );

  nz_env #(.VOL_W(VOL_W)) u_env (
    .clk(clk), .rst(rst), .qtr_tick(qtr_tick), .restart(load_wr),
    .loop_en(halt_q), .const_vol(constv_q), .setting(vol_q), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out <= '0;
    end else if ((len_cnt != '0) && !lfsr_q[0]) begin
      sample_out <= level;
    end else begin
      sample_out <= '0;
    end
  end

endmodule

// File: rtl/noise_voice_chk.sv
module noise_voice_chk #(
  parameter int LEN_W  = 8,
  parameter int LFSR_W = 15,
  parameter int VOL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              len_busy,
  input logic              half_tick,
  input logic              shift_tick,
  input logic [LEN_W-1:0]  len_cnt,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [VOL_W-1:0]  sample_out
);

  assert_len_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (len_cnt == '0));

  assert_silent_no_len_R4: assert property (@(posedge clk) disable iff (rst)
    (len_cnt == '0) |=> (sample_out == '0));

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    (lfsr_q != '0));

  assert_lfsr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_tick |=> $stable(lfsr_q));

  assert_load_refused_R9: assert property (@(posedge clk) disable iff (rst)
    (chan_en && wr_en && (wr_sel == 2'd3) && len_busy && (len_cnt != '0) && !half_tick)
    |=> $stable(len_cnt));

endmodule

bind noise_voice noise_voice_chk #(.LEN_W(LEN_W), .LFSR_W(LFSR_W), .VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .len_busy(len_busy), .half_tick(half_tick), .shift_tick(shift_tick),
  .len_cnt(len_cnt), .lfsr_q(lfsr_q), .sample_out(sample_out)
);

// File: tb/sim_noise_voice.sv
module sim_noise_voice;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       qtr_tick = 1'b0;
  logic       half_tick = 1'b0;
  logic       chan_en = 1'b0;
  logic       len_busy = 1'b0;
  logic [3:0] sample_out;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  logic [3:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  noise_voice u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .qtr_tick(qtr_tick), .half_tick(half_tick), .chan_en(chan_en),
    .len_busy(len_busy), .sample_out(sample_out)
  );

  // Predictor state, built from the requirements
  logic [14:0] m_lfsr;
  logic [11:0] m_cnt;
  logic [7:0]  m_len;
  logic        m_start;
  logic [3:0]  m_div, m_dec, m_vol, m_idx;
  logic        m_halt, m_const, m_mode;
  logic [3:0]  e_val, n_div, n_dec;
  logic        n_start;

  function automatic logic [11:0] per_of(input logic [3:0] i);
    return (i == 4'd3) ? 12'd32 : 12'd4;        // R5 values
  endfunction

  function automatic logic [7:0] len_of(input logic [4:0] i);
    case (i)
      5'd1:    return 8'd254;                      // R6 values
      5'd3:    return 8'd2;
      5'd5:    return 8'd4;
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr = 15'd1; m_cnt = 12'd1; m_len = 8'd0;
      m_start = 1'b0; m_div = 4'd0; m_dec = 4'd0;
      m_vol = 4'd0; m_idx = 4'd0; m_halt = 1'b0; m_const = 1'b0; m_mode = 1'b0;
      e_val = 4'd0;
    end else begin
      e_val = ((m_len != 8'd0) && !m_lfsr[0]) ? (m_const ? m_vol : m_dec) : 4'd0;
      n_start = m_start; n_div = m_div; n_dec = m_dec;
      if (qtr_tick) begin
        if (m_start) begin
          n_start = 1'b0; n_dec = 4'd15; n_div = m_vol;
        end else if (m_div == 4'd0) begin
          n_div = m_vol;
          if (m_dec != 4'd0) n_dec = m_dec - 4'd1;
          else if (m_halt) n_dec = 4'd15;
        end else begin
          n_div = m_div - 4'd1;
        end
      end
      if (wr_en && wr_sel == 2'd3) n_start = 1'b1;
      if (!chan_en) m_len = 8'd0;
      else if (wr_en && wr_sel == 2'd3 && !(len_busy && m_len != 8'd0)) m_len = len_of(wr_data[7:3]);
      else if (half_tick && !m_halt && m_len != 8'd0) m_len = m_len - 8'd1;
      if (m_cnt <= 12'd1) begin
        m_cnt  = per_of(m_idx);
        m_lfsr = {m_lfsr[0] ^ (m_mode ? m_lfsr[6] : m_lfsr[1]), m_lfsr[14:1]};
      end else begin
        m_cnt = m_cnt - 12'd1;
      end
      m_start = n_start; m_div = n_div; m_dec = n_dec;
      if (wr_en && wr_sel == 2'd0) begin
        m_halt = wr_data[5]; m_const = wr_data[4]; m_vol = wr_data[3:0];
      end
      if (wr_en && wr_sel == 2'd2) begin
        m_mode = wr_data[7]; m_idx = wr_data[3:0];
      end
    end
    exp_q.push_back(e_val);
  end

  // Monitor: pops one prediction per cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      n_checks++;
      if (sample_out !== e) begin
        n_fails++;
        $display("FAIL %s sample_out=%0d expected=%0d", cur_req, sample_out, e);
      end
    end
  end

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d,
                     input logic hf, input logic bz, input logic qt);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; half_tick = hf; len_busy = bz; qtr_tick = qt;
    @(negedge clk);
    wr_en = 1'b0; half_tick = 1'b0; len_busy = 1'b0; qtr_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    cur_req = "R1";
    n_checks++;
    if (sample_out !== 4'd0) begin
      n_fails++;
      $display("FAIL R1 reset sample=%0d expected=0", sample_out);
    end
    @(negedge clk); rst = 1'b0; chan_en = 1'b1;
    idle(6);

    cur_req = "R10";
    cyc(1'b1, 2'd0, 8'h1F, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h08, 1'b0, 1'b0, 1'b0);
    idle(120);

    cur_req = "R3";
    cyc(1'b1, 2'd2, 8'h80, 1'b0, 1'b0, 1'b0);
    idle(200);

    cur_req = "R5";
    cyc(1'b1, 2'd2, 8'h83, 1'b0, 1'b0, 1'b0);
    idle(400);
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0);

    cur_req = "R6";
    cyc(1'b1, 2'd3, 8'h28, 1'b0, 1'b0, 1'b0);   // length 4
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
      idle(12);
    end

    cur_req = "R7";
    cyc(1'b1, 2'd0, 8'h3F, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h18, 1'b0, 1'b0, 1'b0);   // length 2, halted
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
      idle(10);
    end

    cur_req = "R8";
    @(negedge clk); chan_en = 1'b0;
    idle(4);
    cyc(1'b1, 2'd3, 8'h08, 1'b0, 1'b0, 1'b0);
    @(negedge clk); chan_en = 1'b1;
    idle(40);

    cur_req = "R9";
    cyc(1'b1, 2'd0, 8'h1F, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h18, 1'b0, 1'b0, 1'b0);   // length 2
    idle(10);
    cyc(1'b1, 2'd3, 8'h08, 1'b1, 1'b1, 1'b0);   // refused, count 1
    idle(20);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);   // count 0
    idle(20);
    cyc(1'b1, 2'd3, 8'h28, 1'b1, 1'b1, 1'b0);   // zero count: accepted, 4
    idle(20);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
      idle(10);
    end

    cur_req = "R11";
    cyc(1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h08, 1'b0, 1'b0, 1'b1);   // restart on a quarter strobe
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
      idle(9);
    end
    cyc(1'b1, 2'd0, 8'h20, 1'b0, 1'b0, 1'b0);   // loop, divider 0
    cyc(1'b1, 2'd3, 8'h08, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
      idle(9);
    end

    cur_req = "R4";
    idle(50);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule